// File: doc/BRIEF.md
# DMA Channel Interrupt Flag Unit

This unit keeps the interrupt status of each DMA channel and drives one interrupt line per channel. The transfer engine feeds it a pulse each time a channel finishes one data item. With that pulse comes the channel's remaining item count, taken before the finished item is subtracted, and the channel's programmed total. From these values the unit raises a transfer-complete flag and a half-transfer flag. A separate error pulse per channel raises an error flag. The unit does not detect errors itself.

Software reads all flags as one packed, read-only status word at byte offset 0x80. It clears individual flags by writing ones to a write-one-to-clear register at offset 0x84. Each interrupt line combines its channel's flags with that channel's three enable inputs.

Top module: `dma_irq_flags`

## Requirements
- R1: After reset, every flag is 0, every interrupt line is low and the status word reads as 0.
- R2: A read at offset 0x80 returns the status word. Channel i owns bits 4i+3..4i, laid out as {error, half, complete, any}. A read at any other offset returns 0.
- R3: The complete flag of a channel is set on the clock edge where its item-done pulse is high and its remaining count is 1.
- R4: The half flag is set on the clock edge where an item-done pulse is high and (remaining count − 1) equals the programmed total shifted right by one. A remaining count that equals this value without an item-done pulse sets nothing. With a total of 1, a single item sets both the half flag and the complete flag.
- R5: The error flag of a channel is set on the clock edge where its error pulse input is high.
- R6: The "any" bit of a channel is the OR of its complete, half and error flags.
- R7: A write to offset 0x84 clears every flag whose matching data bit (4i+1, 4i+2 or 4i+3) is 1. Data bits that are 0 leave their flags unchanged, and flags of other channels are untouched.
- R8: If a set event and a clear hit the same flag in the same cycle, the flag ends up set.
- R9: A channel's interrupt line is high when any of its flags is set together with the matching enable input (complete, half, error).
- R10: Writes to any offset other than 0x84, including the status offset 0x80, change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| item_done_i | input | NCH | Per-channel pulse: one item finished |
| remain_i | input | NCH*CW | Per-channel remaining count before the finished item |
| total_i | input | NCH*CW | Per-channel programmed item total |
| err_i | input | NCH | Per-channel error pulse |
| tc_ie_i | input | NCH | Complete interrupt enable per channel |
| ht_ie_i | input | NCH | Half interrupt enable per channel |
| te_ie_i | input | NCH | Error interrupt enable per channel |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | AW | Register byte offset |
| wdata_i | input | DW | Register write data |
| rdata_o | output | DW | Register read data (combinational) |
| irq_o | output | NCH | Per-channel interrupt line |

## Verification
The assertions assume that the remaining count and programmed total are stable and valid in every cycle where an item-done pulse is high. They also assume that write data and address are meaningful only while the write strobe is high. The stimulus sets counts, totals, address and data at the falling edge, before or together with the pulse, and returns all strobes to zero at the next falling edge. Every pulse therefore covers exactly one rising edge. Collisions between a set and a clear are produced deliberately, by driving both in the same cycle.

// File: rtl/dma_irq_flags.sv
module dma_irq_flags #(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int AW  = 8,
  parameter int DW  = 32,
  parameter logic [AW-1:0] STAT_OFS = 'h80,
  parameter logic [AW-1:0] CLR_OFS  = 'h84
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    item_done_i,
  input  logic [NCH*CW-1:0] remain_i,
  input  logic [NCH*CW-1:0] total_i,
  input  logic [NCH-1:0]    err_i,
  input  logic [NCH-1:0]    tc_ie_i,
  input  logic [NCH-1:0]    ht_ie_i,
  input  logic [NCH-1:0]    te_ie_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NCH-1:0]    irq_o
);
  localparam int SW = 4 * NCH;

  logic [NCH-1:0] tc_q, ht_q, te_q;
  logic [NCH-1:0] tc_set, ht_set;
  logic [NCH-1:0] tc_clr, ht_clr, te_clr;
  logic [SW-1:0]  stat;

  wire clr_wr = wr_en_i && (addr_i == CLR_OFS);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    wire [CW-1:0] rem = remain_i[g*CW +: CW];
    wire [CW-1:0] tot = total_i[g*CW +: CW];

    assign tc_set[g] = item_done_i[g] && (rem == CW'(1));
    assign ht_set[g] = item_done_i[g] && ((rem - CW'(1)) == (tot >> 1));
    assign tc_clr[g] = clr_wr && wdata_i[4*g+1];
    assign ht_clr[g] = clr_wr && wdata_i[4*g+2];
    assign te_clr[g] = clr_wr && wdata_i[4*g+3];
    assign stat[4*g +: 4] = {te_q[g], ht_q[g], tc_q[g], tc_q[g] | ht_q[g] | te_q[g]};

    AST_TC_SET: assert property (@(posedge clk) disable iff (!rst_n)
      item_done_i[g] && rem == CW'(1) |=> tc_q[g]);                          // R3
    AST_HT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      item_done_i[g] && (rem - CW'(1)) == (tot >> 1) |=> ht_q[g]);           // R4
    AST_TE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      err_i[g] |=> te_q[g]);                                                 // R5
    AST_TC_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i && addr_i == CLR_OFS && wdata_i[4*g+1] && !item_done_i[g]
      |=> !tc_q[g]);                                                         // R7
    AST_TE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !err_i[g] && !(wr_en_i && addr_i == CLR_OFS) |=> $stable(te_q[g]));   // R10
    AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[g] |-> (stat[4*g+1] || stat[4*g+2] || stat[4*g+3]));            // R9
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tc_q <= '0;
      ht_q <= '0;
      te_q <= '0;
    end else begin
      tc_q <= tc_set | (tc_q & ~tc_clr);
      ht_q <= ht_set | (ht_q & ~ht_clr);
      te_q <= err_i  | (te_q & ~te_clr);
    end
  end

  assign rdata_o = (addr_i == STAT_OFS) ? DW'(stat) : '0;
  assign irq_o   = (tc_q & tc_ie_i) | (ht_q & ht_ie_i) | (te_q & te_ie_i);

  AST_RST_CLEAN: assert property (@(posedge clk) !rst_n |=> stat == '0);    // R1
endmodule

// File: tb/dma_irq_flags_tb_top.sv
module dma_irq_flags_tb_top;
  localparam int NCH = 4, CW = 16, AW = 8, DW = 32;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] item_done = '0, err = '0, tc_ie = '0, ht_ie = '0, te_ie = '0;
  logic [NCH*CW-1:0] remain = '0, total = '0;
  logic wr_en = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [NCH-1:0] irq;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  dma_irq_flags #(.NCH(NCH), .CW(CW), .AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .item_done_i(item_done), .remain_i(remain),
    .total_i(total), .err_i(err), .tc_ie_i(tc_ie), .ht_ie_i(ht_ie), .te_ie_i(te_ie),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic read_stat(output logic [31:0] v);
    addr = 8'h80; #1; v = rdata;
  endtask

  task automatic set_cnt(input int ch, input int rem, input int tot);
    remain[ch*CW +: CW] = CW'(rem);
    total[ch*CW +: CW]  = CW'(tot);
  endtask

  task automatic step;
    @(negedge clk);
    item_done = '0; err = '0; wr_en = 0; wdata = '0;
  endtask

  task automatic item(input int ch, input int rem, input int tot);
    set_cnt(ch, rem, tot); item_done[ch] = 1'b1; step();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1; step();
  endtask

  task automatic t_reset;
    logic [31:0] v;
    read_stat(v); chk("R1 status", v, 0); chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_complete;
    logic [31:0] v;
    item(1, 3, 8); read_stat(v); chk("R3 no tc at rem3", v, 0);
    item(1, 1, 8); read_stat(v); chk("R3 R6 tc ch1", v, 32'h30);
    tc_ie = 4'b0010; #1; chk("R9 tc irq", 32'(irq), 32'h2);
    addr = 8'h88; #1; chk("R2 other offset reads 0", rdata, 0);
    wr(8'h84, 32'h20); read_stat(v); chk("R7 clear tc ch1", v, 0);
    chk("R9 irq drops", 32'(irq), 0); tc_ie = '0;
  endtask

  task automatic t_half;
    logic [31:0] v;
    set_cnt(2, 5, 10); step(); read_stat(v); chk("R4 no ht without item", v, 0);
    item(2, 7, 10); read_stat(v); chk("R4 no ht at rem7", v, 0);
    item(2, 6, 10); read_stat(v); chk("R4 R2 ht ch2", v, 32'h500);
    #1; chk("R9 ht disabled", 32'(irq), 0);
    ht_ie = 4'b0100; #1; chk("R9 ht irq", 32'(irq), 32'h4); ht_ie = '0;
    wr(8'h84, 32'h400); read_stat(v); chk("R7 clear ht", v, 0);
  endtask

  task automatic t_err;
    logic [31:0] v;
    err[3] = 1; step(); read_stat(v); chk("R5 R6 te ch3", v, 32'h9000);
    te_ie = 4'b1000; #1; chk("R9 te irq", 32'(irq), 32'h8); te_ie = '0;
    wr(8'h84, 32'h0); read_stat(v); chk("R7 zero write no effect", v, 32'h9000);
    wr(8'h80, 32'hFFFF_FFFF); read_stat(v); chk("R10 write to status ignored", v, 32'h9000);
    wr(8'h88, 32'hFFFF_FFFF); read_stat(v); chk("R10 write to other offset ignored", v, 32'h9000);
    wr(8'h84, 32'h8000); read_stat(v); chk("R7 clear te", v, 0);
  endtask

  task automatic t_isolation;
    logic [31:0] v;
    set_cnt(0, 1, 4); set_cnt(3, 1, 4); item_done = 4'b1001; step();
    read_stat(v); chk("R3 tc ch0 and ch3", v, 32'h3003);
    wr(8'h84, 32'h2); read_stat(v); chk("R7 other channel untouched", v, 32'h3000);
    wr(8'h84, 32'h2000); read_stat(v); chk("R7 ch3 cleared", v, 0);
  endtask

  task automatic t_setwins;
    logic [31:0] v;
    set_cnt(0, 1, 4); item_done[0] = 1; addr = 8'h84; wdata = 32'h2; wr_en = 1; step();
    read_stat(v); chk("R8 set beats clear", v, 32'h3);
    err[0] = 1; addr = 8'h84; wdata = 32'hA; wr_en = 1; step();
    read_stat(v); chk("R8 te set beats clear, tc cleared", v, 32'h9);
    wr(8'h84, 32'hFFFF_FFFF); read_stat(v); chk("R7 clear all", v, 0);
  endtask

  task automatic t_total_one;
    logic [31:0] v;
    item(0, 1, 1); read_stat(v); chk("R4 R3 total 1 sets ht and tc", v, 32'h7);
    wr(8'h84, 32'h6); read_stat(v); chk("R7 clear both", v, 0);
  endtask

  task automatic t_rereset;
    logic [31:0] v;
    err = 4'hF; step(); rst_n = 0; step(); rst_n = 1; step();
    read_stat(v); chk("R1 reset clears flags", v, 0);
  endtask

  initial begin
    step(); step(); rst_n = 1; step();
    t_reset(); t_complete(); t_half(); t_err();
    t_isolation(); t_setwins(); t_total_one(); t_rereset();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule